// File: doc/BRIEF.md
# Configurable Dual Storage Element

This block holds two single-bit storage elements that share one clock, one clock enable and one pair of force controls. A static configuration, fixed at elaboration, shapes each element. It selects edge-triggered capture or level-sensitive transparency, and it selects the value that the force input drives. It also sets the value loaded at initialisation, which does not have to match the forced value. Shared options select synchronous or asynchronous forcing, the active sense of every control input, and whether the clock enable and the force inputs are in use at all.

The force input drives each element to its configured forced value. A second input, the reverse force, drives the opposite value. When both directions are requested together, the drive toward 0 wins. An initialisation pulse loads the initial values into both elements at once, without waiting for a clock, and overrides every other input. The block is meant as a building block for a fabric-style logic cell in which each flop's behaviour comes from configuration rather than from rewritten logic.

Top module: `cfgstore_pair`

## Requirements
- R1: In flip-flop mode, an element takes its data input on the active clock edge when no force is active and the clock enable is active. With default polarity the clock is active on the rising edge and the enable is active at 1.
- R2: When the clock enable is inactive and no force is active, an element holds its value. When CE_USED is 0, the enable input is ignored and the element behaves as if the enable were always active.
- R3: An active force input drives each element to its own bit of SR_VAL_MASK, where bit i belongs to lane i and a 1 means drive high.
- R4: An active reverse input drives each element to the inverse of its SR_VAL_MASK bit. The reverse input has effect only when both SR_USED and REV_USED are 1. When SR_USED is 0, both the force input and the reverse input are ignored.
- R5: When the force input and the reverse input together ask an element for both 1 and 0, the element goes to 0.
- R6: With synchronous forcing (SR_ASYNC = 0), force and reverse change an element only at an active clock edge, and they act whatever the clock enable is.
- R7: With asynchronous forcing (SR_ASYNC = 1), force and reverse change an element as soon as they become active, with no clock edge.
- R8: An element in latch mode (its LATCH_MASK bit is 1) follows its data input while the clock level is active and the enable is active. At any other time it holds its value.
- R9: A high init drives each element at once to its own bit of INIT_MASK, which is independent of SR_VAL_MASK, and init overrides every other input.
- R10: CLK_INV, CE_INV, SR_INV and REV_INV each invert the active sense of their input. With CLK_INV set, capture happens on the falling edge and latches are transparent while the clock is low.
- R11: Clock, enable, force and reverse are common to all lanes. Each lane has its own data input bit d[i] and its own output bit q[i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; its active edge or level is set by CLK_INV |
| init | input | 1 | Asynchronous initialisation, active high; loads INIT_MASK |
| ce | input | 1 | Shared clock enable; its sense is set by CE_INV |
| sr | input | 1 | Shared force toward each lane's SR_VAL_MASK bit; its sense is set by SR_INV |
| rev | input | 1 | Shared reverse force toward the opposite value; its sense is set by REV_INV |
| d | input | LANES | One data bit per lane |
| q | output | LANES | One stored bit per lane |

## Verification
Two of this block's functions can fall in the same cycle: a force toward 1 and a force toward 0 on the same element. This happens when the force input and the reverse input are active together, because they push each lane in opposite directions. The bench raises both on one clock edge in the synchronous configuration, and raises both as levels between edges in the asynchronous one. In each case it expects every lane to read 0, whatever that lane's forced value is. Init against force is exercised in the same way: init is pulsed while a force and data are waiting, and the bench expects the initial values both at once and after the following edge.

// File: rtl/cfgstore_pkg.sv
`timescale 1ns/100ps
package cfgstore_pkg;

  // Control inputs after the polarity and usage options are applied.
  typedef struct packed {
    logic ce;
    logic sr;
    logic rev;
  } ctl_t;

  // An unused control reads as its idle value; a used one gets its sense applied.
  function automatic logic apply_pol(input logic raw, input bit inv,
                                     input bit used, input logic idle);
    return used ? (raw ^ inv) : idle;
  endfunction

endpackage

// File: rtl/cfgstore_ctrl.sv
`timescale 1ns/100ps
module cfgstore_ctrl
  import cfgstore_pkg::*;
#(
  parameter bit CLK_INV  = 1'b0,
  parameter bit CE_INV   = 1'b0,
  parameter bit SR_INV   = 1'b0,
  parameter bit REV_INV  = 1'b0,
  parameter bit CE_USED  = 1'b1,
  parameter bit SR_USED  = 1'b1,
  parameter bit REV_USED = 1'b1
) (
  input  logic clk,
  input  logic ce,
  input  logic sr,
  input  logic rev,
  output logic ck_act,
  output ctl_t ctl
);

  localparam bit REV_LIVE = SR_USED && REV_USED;

  // The active clock sense: the inversion sits on the control input.
  assign ck_act  = clk ^ CLK_INV;

  assign ctl.ce  = apply_pol(ce,  CE_INV,  CE_USED,  1'b1);
  assign ctl.sr  = apply_pol(sr,  SR_INV,  SR_USED,  1'b0);
  assign ctl.rev = apply_pol(rev, REV_INV, REV_LIVE, 1'b0);

endmodule

// File: rtl/cfgstore_dir.sv
`timescale 1ns/100ps
module cfgstore_dir #(
  parameter bit SR_HIGH = 1'b0
) (
  input  logic sr_on,
  input  logic rev_on,
  output logic set_dir,
  output logic rst_dir
);

  // The force input pushes toward SR_HIGH; the reverse input pushes the other way.
  generate
    if (SR_HIGH) begin : g_sr_sets
      assign set_dir = sr_on;
      assign rst_dir = rev_on;
    end else begin : g_sr_clears
      assign set_dir = rev_on;
      assign rst_dir = sr_on;
    end
  endgenerate

endmodule

// File: rtl/cfgstore_cell.sv
`timescale 1ns/100ps
module cfgstore_cell #(
  parameter bit IS_LATCH = 1'b0,
  parameter bit ASYNC_SR = 1'b0,
  parameter bit INIT_BIT = 1'b0
) (
  input  logic ck_act,
  input  logic init,
  input  logic ce_en,
  input  logic set_dir,
  input  logic rst_dir,
  input  logic d,
  output logic q
);

  logic frc;
  logic frc_val;

  assign frc     = set_dir | rst_dir;
  assign frc_val = ~rst_dir;   // a drive toward 0 wins over a drive toward 1

  generate
    if (IS_LATCH) begin : g_latch
      always_latch begin
        if (init) begin
          q <= INIT_BIT;
        end else if (ASYNC_SR && frc) begin
          q <= frc_val;
        end else if (ck_act) begin
          if (!ASYNC_SR && frc) begin
            q <= frc_val;
          end else if (ce_en) begin
            q <= d;
          end
        end
      end

      // R8: at the closing edge, a transparent latch holds the data it was following.
      p_latch_track_r8: assert property (@(negedge ck_act) disable iff (init)
        (ce_en && !frc) |-> (q == d));

    end else if (ASYNC_SR) begin : g_ff_async
      always_ff @(posedge ck_act or posedge init or posedge rst_dir or posedge set_dir) begin
        if (init) begin
          q <= INIT_BIT;
        end else if (rst_dir) begin
          q <= 1'b0;
        end else if (set_dir) begin
          q <= 1'b1;
        end else if (ce_en) begin
          q <= d;
        end
      end

      // R7: a held drive toward 0 is already visible at any clock edge.
      p_async_rst_r7: assert property (@(posedge ck_act) disable iff (init)
        rst_dir |-> !q);

    end else begin : g_ff_sync
      always_ff @(posedge ck_act or posedge init) begin
        if (init) begin
          q <= INIT_BIT;
        end else if (frc) begin
          q <= frc_val;
        end else if (ce_en) begin
          q <= d;
        end
      end

      // R1: enabled capture of data.
      p_capture_r1: assert property (@(posedge ck_act) disable iff (init)
        (!frc && ce_en) |=> (q == $past(d)));

      // R2: a disabled element holds its value.
      p_hold_r2: assert property (@(posedge ck_act) disable iff (init)
        (!frc && !ce_en) |=> $stable(q));

      // R6: a synchronous force lands on the edge whatever the enable is.
      p_sync_force_r6: assert property (@(posedge ck_act) disable iff (init)
        frc |=> (q == $past(frc_val)));
    end
  endgenerate

endmodule

// File: rtl/cfgstore_pair.sv
`timescale 1ns/100ps
module cfgstore_pair
  import cfgstore_pkg::*;
#(
  parameter int               LANES       = 2,
  parameter logic [LANES-1:0] LATCH_MASK  = '0,
  parameter logic [LANES-1:0] SR_VAL_MASK = 2'b10,
  parameter logic [LANES-1:0] INIT_MASK   = 2'b01,
  parameter bit               SR_ASYNC    = 1'b0,
  parameter bit               CLK_INV     = 1'b0,
  parameter bit               CE_INV      = 1'b0,
  parameter bit               SR_INV      = 1'b0,
  parameter bit               REV_INV     = 1'b0,
  parameter bit               CE_USED     = 1'b1,
  parameter bit               SR_USED     = 1'b1,
  parameter bit               REV_USED    = 1'b1
) (
  input  logic             clk,
  input  logic             init,
  input  logic             ce,
  input  logic             sr,
  input  logic             rev,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);

  logic ck_act;
  ctl_t ctl;

  // R10, R11: one conditioned set of controls, shared by every lane.
  cfgstore_ctrl #(
    .CLK_INV (CLK_INV),
    .CE_INV  (CE_INV),
    .SR_INV  (SR_INV),
    .REV_INV (REV_INV),
    .CE_USED (CE_USED),
    .SR_USED (SR_USED),
    .REV_USED(REV_USED)
  ) u_ctrl (
    .clk   (clk),
    .ce    (ce),
    .sr    (sr),
    .rev   (rev),
    .ck_act(ck_act),
    .ctl   (ctl)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic set_dir;
      logic rst_dir;

      cfgstore_dir #(
        .SR_HIGH(SR_VAL_MASK[i])
      ) u_dir (
        .sr_on  (ctl.sr),
        .rev_on (ctl.rev),
        .set_dir(set_dir),
        .rst_dir(rst_dir)
      );

      cfgstore_cell #(
        .IS_LATCH(LATCH_MASK[i]),
        .ASYNC_SR(SR_ASYNC),
        .INIT_BIT(INIT_MASK[i])
      ) u_cell (
        .ck_act (ck_act),
        .init   (init),
        .ce_en  (ctl.ce),
        .set_dir(set_dir),
        .rst_dir(rst_dir),
        .d      (d[i]),
        .q      (q[i])
      );
    end
  endgenerate

endmodule

// File: tb/cfgstore_pair_test.sv
`timescale 1ns/100ps
module cfgstore_pair_test;

  logic       clk  = 1'b0;
  logic       init = 1'b1;
  // Default instance: synchronous flops, SR_VAL_MASK=10, INIT_MASK=01.
  logic       ce = 1'b0, sr = 1'b0, rev = 1'b0;
  logic [1:0] d = 2'b00;
  logic [1:0] q;
  // Alternate instance: lane0 latch, lane1 flop, async force, inverted clk/ce/sr.
  logic       a_ce = 1'b1, a_sr = 1'b1, a_rev = 1'b0;
  logic [1:0] a_d = 2'b00;
  logic [1:0] aq;
  // Instance without enable or force in use.
  logic       n_ce = 1'b0, n_sr = 1'b1, n_rev = 1'b1;
  logic [1:0] n_d = 2'b00;
  logic [1:0] nq;

  int runs  = 0;
  int fails = 0;

  always #2 clk = ~clk;   // 250 MHz

  cfgstore_pair uut (
    .clk(clk), .init(init), .ce(ce), .sr(sr), .rev(rev), .d(d), .q(q)
  );

  cfgstore_pair #(
    .LATCH_MASK(2'b01), .SR_VAL_MASK(2'b01), .INIT_MASK(2'b00),
    .SR_ASYNC(1'b1), .CLK_INV(1'b1), .CE_INV(1'b1), .SR_INV(1'b1)
  ) u_alt (
    .clk(clk), .init(init), .ce(a_ce), .sr(a_sr), .rev(a_rev), .d(a_d), .q(aq)
  );

  cfgstore_pair #(
    .CE_USED(1'b0), .SR_USED(1'b0)
  ) u_nce (
    .clk(clk), .init(init), .ce(n_ce), .sr(n_sr), .rev(n_rev), .d(n_d), .q(nq)
  );

  // Row layout {ce, sr, rev, d[1:0], expected q[1:0]}; the walk starts from q=01.
  localparam int NV = 12;
  localparam logic [6:0] VEC [NV] = '{
    7'b1001010, 7'b1000101, 7'b0001001, 7'b0101110,
    7'b1001111, 7'b1010001, 7'b0111100, 7'b1001111,
    7'b1100010, 7'b1000000, 7'b0011101, 7'b1001010
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    init = 1'b0;
    chk("R9 reset state default", q, 2'b01);
    chk("R9 reset state alternate", aq, 2'b00);
    chk("R9 reset state unused-controls", nq, 2'b01);

    // R1 R2 R3 R4 R5 R6: table walk on the default instance.
    for (int i = 0; i < NV; i++) begin
      {ce, sr, rev, d} = VEC[i][6:2];
      @(posedge clk); #1;
      chk($sformatf("R1/R2/R3/R4/R5/R6 row %0d", i), q, VEC[i][1:0]);
    end

    // R6: a synchronous force waits for the edge.
    ce = 1'b1; d = 2'b11; sr = 1'b0;
    @(posedge clk); #1;
    chk("R1 load before sync force", q, 2'b11);
    sr = 1'b1; ce = 1'b0;
    #0.5;
    chk("R6 no change before edge", q, 2'b11);
    @(posedge clk); #1;
    chk("R6 force on edge", q, 2'b10);
    sr = 1'b0;

    // R9: init overrides a pending force and enabled data.
    ce = 1'b1; d = 2'b00; sr = 1'b1;
    #0.5 init = 1'b1;
    #0.5;
    chk("R9 immediate init load", q, 2'b01);
    @(posedge clk); #1;
    chk("R9 init overrides force", q, 2'b01);
    init = 1'b0; sr = 1'b0; ce = 1'b0;

    // R8 R10: lane0 latch transparent while clk low; lane1 captures on falling edge.
    @(posedge clk); #1;
    a_ce = 1'b0; a_d = 2'b01;
    #0.5;
    chk("R8 latch closed while clk high", aq, 2'b00);
    @(negedge clk); #1;
    chk("R10 falling-edge capture, low-level transparency", aq, 2'b01);
    a_d = 2'b00;
    #0.5;
    chk("R8 latch follows data", aq, 2'b00);
    @(posedge clk); #1;
    a_d = 2'b11;
    #0.5;
    chk("R8 latch holds while closed", aq, 2'b00);
    @(negedge clk); #1;
    chk("R1 R11 both lanes load", aq, 2'b11);
    a_ce = 1'b1; a_d = 2'b00;
    #0.5;
    chk("R2 inverted enable inactive, latch holds", aq, 2'b11);
    @(posedge clk); @(negedge clk); #1;
    chk("R2 inverted enable inactive, flop holds", aq, 2'b11);

    // R7 R3 R4 R5: asynchronous force between edges (sr active low here).
    @(posedge clk); #0.5;
    a_sr = 1'b0;
    #0.5;
    chk("R7 R3 async force", aq, 2'b01);
    @(posedge clk); #0.5;
    a_sr = 1'b1;
    #0.5;
    chk("R7 value held after force release", aq, 2'b01);
    @(posedge clk); #0.5;
    a_rev = 1'b1;
    #0.5;
    chk("R7 R4 async reverse", aq, 2'b10);
    @(posedge clk); #0.5;
    a_sr = 1'b0;
    #0.5;
    chk("R5 async both directions", aq, 2'b00);
    a_sr = 1'b1; a_rev = 1'b0;

    // R2 R4: enable and force inputs not in use.
    n_d = 2'b10;
    @(posedge clk); #1;
    chk("R2 R4 unused enable and force ignored", nq, 2'b10);
    n_d = 2'b01;
    @(posedge clk); #1;
    chk("R2 R4 unused enable and force ignored again", nq, 2'b01);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule